// File: doc/BRIEF.md
# Double-Buffered DAC Register Core

This block is the digital front end of a 16-bit parallel-load converter. A host writes a code word into a holding (input) register over a parallel bus. A separate load strobe then moves that word into the output (DAC) register, whose contents drive the converter code. Holding the strobe low during a write passes bus data straight through to the output register. The host can read the pending word back over the same bus before it commits an update.

The control pins are asynchronous to the system clock. They are sampled through a synchroniser, and the chip-select rising edge is found from the synchronised copy. The bus word stored on that edge is the one sampled together with the last low value of chip select.

A level-held, active-low reset forces both registers to one of two preset codes: mid-scale 7FFF hex when the select pin is high, and min-scale FFFF hex when it is low. The converter code output shows the preset while reset is low, and it follows the select pin as soon as the pin changes.

The bus is modelled with separate input, output and output-enable ports. All pins are plain level controls, so there is no valid/ready handshake and no back-pressure: each transfer completes in a fixed number of cycles.

Top module: `dac_dblbuf_core`

## Requirements
- R1: With chip select low and read/write low, the word on the bus is stored in the input register when chip select returns high. The DAC code does not change unless the load strobe is low.
- R2: While the load strobe is low, the DAC register copies the input register, whatever the state of chip select.
- R3: When chip select, read/write and the load strobe are all low, the DAC code follows the bus word directly (transparent mode).
- R4: With chip select low and read/write high, the output enable is high and the data output carries the input register contents. A read changes neither register.
- R5: The output enable is low whenever chip select is high or read/write is low.
- R6: With chip select high and the load strobe high, both registers keep their values.
- R7: While reset is low, the DAC code is 7FFF hex if select is high and FFFF hex if select is low. Both registers are loaded with that code, and every other control is ignored.
- R8: A change of select while reset stays low changes the DAC code to the newly selected preset at once, with no clock edge needed.
- R9: After reset is released, both registers keep the preset code until the next write or load.
- R10: The chip-select rising edge is detected after a two-stage synchroniser. The stored word is the bus value sampled in the last cycle in which chip select was seen low, so a bus change that coincides with the chip-select rise is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all control pins |
| cs_n_i | input | 1 | Chip select, active low |
| rw_i | input | 1 | Bus direction: 1 = read back, 0 = write |
| ld_n_i | input | 1 | Load strobe, active low: moves the input register into the DAC register |
| rst_n_i | input | 1 | Level-held reset to a preset code, active low |
| sel_mid_i | input | 1 | Preset select: 1 = 7FFF hex, 0 = FFFF hex |
| bus_din_i | input | 16 | Data bus, write direction |
| bus_dout_o | output | 16 | Data bus, read direction (input register contents) |
| bus_oe_o | output | 1 | Bus drive enable; when low the bus is high impedance |
| dac_code_o | output | 16 | Code presented to the converter |

## Verification
The assertions count control-pin history in whole clock cycles. They therefore assume that the pins change away from the sampling edge and that reset is released while chip select is high, so that no chip-select edge is lost inside the synchroniser. The stimulus drives every pin on the falling clock edge. It holds each control level for at least three cycles and waits four or more cycles after a change before it samples, so each pin level has passed through the whole synchroniser and the register stage behind it.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  typedef struct packed {
    logic cs_n;
    logic rw;
    logic ld_n;
  } pin_ctl_t;

  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_FROM_IN = 2'd1,
    UPD_FROM_BUS = 2'd2
  } dac_upd_e;

  localparam pin_ctl_t CTL_IDLE = '{cs_n: 1'b1, rw: 1'b1, ld_n: 1'b1};

endpackage

// File: rtl/dac_pin_sampler.sv
module dac_pin_sampler
  import dac_ctrl_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  pin_ctl_t       pins_i,
  input  logic [DW-1:0]  data_i,
  output pin_ctl_t       ctl_now_o,
  output logic           prev_cs_n_o,
  output logic           prev_rw_o,
  output logic [DW-1:0]  data_now_o,
  output logic [DW-1:0]  data_prev_o
);
  localparam int LAST = SYNC_STAGES - 1;

  pin_ctl_t      ctl_pipe  [SYNC_STAGES];
  logic [DW-1:0] data_pipe [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) ctl_pipe[0] <= CTL_IDLE;
        else          ctl_pipe[0] <= pins_i;
      end
      always_ff @(posedge clk_i) data_pipe[0] <= data_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) ctl_pipe[g] <= CTL_IDLE;
        else          ctl_pipe[g] <= ctl_pipe[g-1];
      end
      always_ff @(posedge clk_i) data_pipe[g] <= data_pipe[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev_cs_n_o <= 1'b1;
      prev_rw_o   <= 1'b1;
    end else begin
      prev_cs_n_o <= ctl_pipe[LAST].cs_n;
      prev_rw_o   <= ctl_pipe[LAST].rw;
    end
  end

  always_ff @(posedge clk_i) data_prev_o <= data_pipe[LAST];

  assign ctl_now_o  = ctl_pipe[LAST];
  assign data_now_o = data_pipe[LAST];

endmodule

// File: rtl/dac_ctl_decode.sv
module dac_ctl_decode
  import dac_ctrl_pkg::*;
(
  input  pin_ctl_t ctl_now_i,
  input  logic     prev_cs_n_i,
  input  logic     prev_rw_i,
  output logic     capture_o,
  output dac_upd_e dac_upd_o,
  output logic     read_o
);
  logic direct;

  always_comb begin
    capture_o = ctl_now_i.cs_n & ~prev_cs_n_i & ~prev_rw_i;
    direct    = ~ctl_now_i.cs_n & ~ctl_now_i.rw & ~ctl_now_i.ld_n;
    read_o    = ~ctl_now_i.cs_n & ctl_now_i.rw;
    if (direct)                dac_upd_o = UPD_FROM_BUS;
    else if (!ctl_now_i.ld_n)  dac_upd_o = UPD_FROM_IN;
    else                       dac_upd_o = UPD_HOLD;
  end

endmodule

// File: rtl/dac_reg_pair.sv
module dac_reg_pair
  import dac_ctrl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          force_n_i,
  input  logic [DW-1:0] preset_i,
  input  logic          capture_i,
  input  logic [DW-1:0] cap_data_i,
  input  dac_upd_e      dac_upd_i,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] in_q_o,
  output logic [DW-1:0] dac_q_o
);

  always_ff @(posedge clk_i) begin
    if (!force_n_i) begin
      in_q_o  <= preset_i;
      dac_q_o <= preset_i;
    end else begin
      if (capture_i) in_q_o <= cap_data_i;
      case (dac_upd_i)
        UPD_FROM_BUS: dac_q_o <= bus_data_i;
        UPD_FROM_IN:  dac_q_o <= in_q_o;
        default:      dac_q_o <= dac_q_o;
      endcase
    end
  end

endmodule

// File: rtl/dac_dblbuf_core.sv
module dac_dblbuf_core
  import dac_ctrl_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          cs_n_i,
  input  logic          rw_i,
  input  logic          ld_n_i,
  input  logic          rst_n_i,
  input  logic          sel_mid_i,
  input  logic [DW-1:0] bus_din_i,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] dac_code_o
);
  localparam logic [DW-1:0] MID_CODE = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_CODE = {DW{1'b1}};

  pin_ctl_t      pins, ctl_now;
  logic          prev_cs_n, prev_rw, capture, read_en;
  dac_upd_e      dac_upd;
  logic [DW-1:0] data_now, data_prev, preset, in_q_w, dac_q_w;

  assign pins   = '{cs_n: cs_n_i, rw: rw_i, ld_n: ld_n_i};
  assign preset = sel_mid_i ? MID_CODE : MIN_CODE;

  dac_pin_sampler #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .pins_i      (pins),
    .data_i      (bus_din_i),
    .ctl_now_o   (ctl_now),
    .prev_cs_n_o (prev_cs_n),
    .prev_rw_o   (prev_rw),
    .data_now_o  (data_now),
    .data_prev_o (data_prev)
  );

  dac_ctl_decode u_decode (
    .ctl_now_i   (ctl_now),
    .prev_cs_n_i (prev_cs_n),
    .prev_rw_i   (prev_rw),
    .capture_o   (capture),
    .dac_upd_o   (dac_upd),
    .read_o      (read_en)
  );

  dac_reg_pair #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .force_n_i  (rst_n_i),
    .preset_i   (preset),
    .capture_i  (capture),
    .cap_data_i (data_prev),
    .dac_upd_i  (dac_upd),
    .bus_data_i (data_now),
    .in_q_o     (in_q_w),
    .dac_q_o    (dac_q_w)
  );

  // Reset acts on the outputs without waiting for a clock edge.
  assign dac_code_o = rst_n_i ? dac_q_w : preset;
  assign bus_dout_o = rst_n_i ? in_q_w  : preset;
  assign bus_oe_o   = read_en & rst_n_i;

endmodule

// File: rtl/dac_dblbuf_chk.sv
module dac_dblbuf_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          cs_n_i,
  input logic          ld_n_i,
  input logic          rst_n_i,
  input logic          sel_mid_i,
  input logic          bus_oe_o,
  input logic [DW-1:0] in_q,
  input logic [DW-1:0] dac_q
);
  localparam logic [DW-1:0] MID_CODE = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_CODE = {DW{1'b1}};

  logic [1:0] age = 2'd0;
  always_ff @(posedge clk_i) if (age != 2'd3) age <= age + 2'd1;

  p_reset_load_r7: assert property (@(posedge clk_i) disable iff (age == 2'd0)
    !rst_n_i |=> (dac_q == ($past(sel_mid_i) ? MID_CODE : MIN_CODE))
              && (in_q == ($past(sel_mid_i) ? MID_CODE : MIN_CODE)));

  p_bus_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i || age != 2'd3)
    $past(cs_n_i, 2) |-> !bus_oe_o);

  p_read_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i || age != 2'd3)
    bus_oe_o |=> $stable(in_q));

  p_dac_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i || age != 2'd3)
    $past(ld_n_i, 2) |=> $stable(dac_q));

  p_input_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i || age != 2'd3)
    $past(cs_n_i, 3) |=> $stable(in_q));

endmodule

bind dac_dblbuf_core dac_dblbuf_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .cs_n_i    (cs_n_i),
  .ld_n_i    (ld_n_i),
  .rst_n_i   (rst_n_i),
  .sel_mid_i (sel_mid_i),
  .bus_oe_o  (bus_oe_o),
  .in_q      (in_q_w),
  .dac_q     (dac_q_w)
);

// File: tb/dac_dblbuf_core_tb.sv
module dac_dblbuf_core_tb;
  localparam int DW = 16;
  localparam int K_DAC = 0, K_READ = 1, K_OE = 2;

  typedef struct {
    int            kind;
    logic [DW-1:0] exp;
    string         req;
  } item_t;

  logic clk = 1'b0;
  logic cs_n = 1'b1, rw = 1'b1, ld_n = 1'b1, rst_n = 1'b0, sel = 1'b1;
  logic [DW-1:0] din = '0, dout, code;
  logic oe;
  int checks = 0, errors = 0;
  bit finished = 0;
  item_t sb_q[$];
  event chk_ev, chk_done;

  always #2.5 clk = ~clk;

  dac_dblbuf_core u_dut (
    .clk_i(clk), .cs_n_i(cs_n), .rw_i(rw), .ld_n_i(ld_n), .rst_n_i(rst_n),
    .sel_mid_i(sel), .bus_din_i(din), .bus_dout_o(dout), .bus_oe_o(oe),
    .dac_code_o(code)
  );

  // Monitor: pops expectations and compares them with the ports.
  initial forever begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [DW:0] act, expv;
      it = sb_q.pop_front();
      case (it.kind)
        K_DAC:   begin act = {1'b0, code}; expv = {1'b0, it.exp}; end
        K_READ:  begin act = {oe, dout};   expv = {1'b1, it.exp}; end
        default: begin act = {{DW{1'b0}}, oe}; expv = {{DW{1'b0}}, it.exp[0]}; end
      endcase
      checks++;
      if (act !== expv) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, expv);
      end
    end
    -> chk_done;
  end

  task automatic expect_item(int kind, logic [DW-1:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    -> chk_ev;
    @(chk_done);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic write_word(logic [DW-1:0] d);
    drive_edge(); rw = 1'b0; din = d;
    drive_edge(); cs_n = 1'b0;
    cyc(4);
    expect_item(K_OE, '0, "R5 write keeps bus idle");
    drive_edge(); cs_n = 1'b1; din = ~d;   // R10: new bus value at the CS rise is not stored
    cyc(2);
    drive_edge(); rw = 1'b1;
    cyc(4);
  endtask

  task automatic read_check(logic [DW-1:0] exp, string req);
    drive_edge(); rw = 1'b1; cs_n = 1'b0;
    cyc(4);
    expect_item(K_READ, exp, req);
    drive_edge(); cs_n = 1'b1;
    cyc(4);
    expect_item(K_OE, '0, "R5 bus idle after read");
  endtask

  task automatic load_pulse();
    drive_edge(); ld_n = 1'b0;
    cyc(3);
    drive_edge(); ld_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    cyc(3);
    expect_item(K_DAC, 16'h7FFF, "R7 reset mid-scale");
    expect_item(K_OE, '0, "R5 idle in reset");
    drive_edge(); sel = 1'b0; #1;
    expect_item(K_DAC, 16'hFFFF, "R8 select low in reset");
    drive_edge(); sel = 1'b1; #1;
    expect_item(K_DAC, 16'h7FFF, "R8 select high in reset");
    cyc(2);
    drive_edge(); rst_n = 1'b1;
    cyc(6);
    expect_item(K_DAC, 16'h7FFF, "R9 preset kept after release");
    read_check(16'h7FFF, "R9 input register preset");

    write_word(16'h1234);
    expect_item(K_DAC, 16'h7FFF, "R1 buffered write leaves DAC");
    read_check(16'h1234, "R1 R10 stored word");
    expect_item(K_DAC, 16'h7FFF, "R4 read leaves DAC");
    read_check(16'h1234, "R4 read leaves input register");
    load_pulse();
    expect_item(K_DAC, 16'h1234, "R2 load copies input");
    cyc(12);
    expect_item(K_DAC, 16'h1234, "R6 idle hold");

    write_word(16'hABCD);
    expect_item(K_DAC, 16'h1234, "R6 no load no change");
    load_pulse();
    expect_item(K_DAC, 16'hABCD, "R2 second load");

    // Transparent mode
    drive_edge(); ld_n = 1'b0; rw = 1'b0; din = 16'h5A5A;
    drive_edge(); cs_n = 1'b0;
    cyc(5);
    expect_item(K_DAC, 16'h5A5A, "R3 transparent word");
    drive_edge(); din = 16'h0F0F;
    cyc(5);
    expect_item(K_DAC, 16'h0F0F, "R3 transparent follows bus");
    drive_edge(); cs_n = 1'b1;
    cyc(6);
    drive_edge(); ld_n = 1'b1; rw = 1'b1;
    cyc(4);
    expect_item(K_DAC, 16'h0F0F, "R3 transparent end");
    read_check(16'h0F0F, "R1 transparent also stores input");

    // Reset overrides an active transparent write
    drive_edge(); ld_n = 1'b0; rw = 1'b0; din = 16'h2222; cs_n = 1'b0;
    cyc(5);
    drive_edge(); sel = 1'b0; rst_n = 1'b0; #1;
    expect_item(K_DAC, 16'hFFFF, "R7 reset overrides controls");
    cyc(3);
    expect_item(K_DAC, 16'hFFFF, "R7 reset held min-scale");
    drive_edge(); cs_n = 1'b1; ld_n = 1'b1; rw = 1'b1;
    cyc(4);
    drive_edge(); rst_n = 1'b1;
    cyc(6);
    expect_item(K_DAC, 16'hFFFF, "R9 min-scale kept");
    read_check(16'hFFFF, "R7 input register forced");
    load_pulse();
    expect_item(K_DAC, 16'hFFFF, "R9 load of preset");
    write_word(16'h0001);
    load_pulse();
    expect_item(K_DAC, 16'h0001, "R9 write then load leaves preset");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule